// File: doc/BRIEF.md
# Fault-Propagating Test Cell Array

The block models rows of identical programmable logic cells wired up to test themselves. Each row is a linear chain. Every cell holds two 3-operand combine functions (a transfer function and a feedback function) and two flip-flops. The transfer function of a cell combines the shared activation input with the two link values coming from the previous cell. The feedback function combines the activation input with the cell's own two flip-flop outputs. The two function results of a cell are the link values handed to the next cell, so each cell is at once a circuit under test and part of the path that carries faults. Only the head of a chain (its two external inputs) and its tail (its two outputs) reach the ports.

A single mode input switches every cell between AND-combining and OR-combining. In AND mode a wrong 0 anywhere is absorbed by every later AND and reaches the tail. In OR mode a wrong 1 behaves the same way. Several chains run side by side and share the clock, the mode input and the activation input. Each chain has its own head inputs and tail outputs.

Every node of every cell can be forced to a stuck value. These nodes are the transfer output, the feedback output and both flip-flop outputs. A bench uses this to show that any single stuck-at fault changes a chain's tail in at least one mode.

Top module: `fta_array`

## Requirements
- R1: `sel`=0 selects AND-combining and `sel`=1 selects OR-combining. With no fault forced, a reset is followed by NCELL clock cycles of held inputs. After that, both outputs of chain j equal the combine of `t_in`, `y_in[j]` and `x_in[j]` under the selected mode.
- R2: A synchronous reset (`rst`=1 at a rising edge) loads every flip-flop with the mode's non-controlling value: 1 in AND mode, 0 in OR mode. Set every input of the selected mode to that value and force no fault. Then both outputs of every chain show that value in the cycle right after reset.
- R3: The activation input dominates both outputs in the same cycle when no fault is forced. In AND mode, `t_in`=0 gives all outputs 0. In OR mode, `t_in`=1 gives all outputs 1.
- R4: Fault control bit index (j*NCELL+k)*4+n addresses node n of cell k in chain j. The node codes are 0 for the transfer output, 1 for the feedback output, 2 for the transfer-side flip-flop and 3 for the feedback-side flip-flop. An enable bit of 1 in `flt_en` replaces that node with the matching bit of `flt_val`.
- R5: Set up the sensitizing pattern: AND mode with all inputs at 1, or OR mode with all inputs at 0. A single stuck fault at the mode's controlling value, on any node of any cell other than the last, drives both outputs of that chain to the controlling value within NCELL cycles.
- R6: In the last cell of a chain, a stuck transfer output sets both tail outputs. A stuck feedback output or a stuck flip-flop sets only `x_out` and leaves `y_out` at its fault-free value.
- R7: Under the sensitizing pattern, a single stuck fault at the non-controlling value leaves every output at its fault-free value.
- R8: A fault forced in one chain never changes the outputs of any other chain.
- R9: Every single stuck-at-0 and stuck-at-1 fault on every node is detected, meaning a tail output differs from the fault-free value, in at least one of the two modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all cells |
| rst | input | 1 | Synchronous active-high reset, loads the mode's non-controlling value |
| sel | input | 1 | Combine mode: 0 AND, 1 OR |
| t_in | input | 1 | Shared fault activation input |
| y_in | input | NCH | Head transfer link per chain |
| x_in | input | NCH | Head feedback link per chain |
| flt_en | input | NCH*NCELL*4 | Stuck-at enables, one per node |
| flt_val | input | NCH*NCELL*4 | Stuck values, one per node |
| y_out | output | NCH | Tail transfer output per chain |
| x_out | output | NCH | Tail feedback output per chain |

## Verification
Random fault-free patterns of mode, activation and per-chain head values are compared against the plain combine. This separates the two modes and shows the activation input and both head links all reach the tail. A full sweep forces each node of each cell to 0 and then to 1, under the sensitizing pattern of each mode. The controlling-value faults tell a mid-chain fault (both tails flip) apart from a last-cell fault (only the feedback tail flips unless the transfer output is stuck). The non-controlling faults and the untouched neighbour chains must stay at the fault-free level. Directed cases cover the reset level and the activation input dominating the outputs.

// File: rtl/fta_pkg.sv
package fta_pkg;

    typedef enum logic {
        PROP_AND = 1'b0,
        PROP_OR  = 1'b1
    } prop_mode_e;

    localparam int NODES   = 4;
    localparam int NODE_G  = 0;
    localparam int NODE_F  = 1;
    localparam int NODE_QY = 2;
    localparam int NODE_QX = 3;

    // Stuck-at controls for the nodes of one cell
    typedef struct packed {
        logic [NODES-1:0] en;
        logic [NODES-1:0] val;
    } inject_t;

    function automatic logic merge3(prop_mode_e m, logic a, logic b, logic c);
        return (m == PROP_OR) ? (a | b | c) : (a & b & c);
    endfunction

    // Value that does not control the combine in this mode
    function automatic logic idle_level(prop_mode_e m);
        return (m == PROP_AND);
    endfunction

    function automatic logic force_node(logic en, logic val, logic raw);
        return en ? val : raw;
    endfunction

endpackage

// File: rtl/fta_cell.sv
module fta_cell
    import fta_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  prop_mode_e mode,
    input  logic       t,
    input  logic       y_prev,
    input  logic       x_prev,
    input  inject_t    inj,
    output logic       g_o,
    output logic       f_o
);
    logic qy_q, qx_q;
    logic qy_eff, qx_eff;

    always_comb begin
        g_o    = force_node(inj.en[NODE_G], inj.val[NODE_G],
                            merge3(mode, t, y_prev, x_prev));
        qy_eff = force_node(inj.en[NODE_QY], inj.val[NODE_QY], qy_q);
        qx_eff = force_node(inj.en[NODE_QX], inj.val[NODE_QX], qx_q);
        f_o    = force_node(inj.en[NODE_F], inj.val[NODE_F],
                            merge3(mode, t, qy_eff, qx_eff));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            qy_q <= idle_level(mode);
            qx_q <= idle_level(mode);
        end else begin
            qy_q <= g_o;
            qx_q <= f_o;
        end
    end

endmodule

// File: rtl/fta_chain.sv
module fta_chain
    import fta_pkg::*;
#(
    parameter int NCELL = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  prop_mode_e             mode,
    input  logic                   t,
    input  logic                   y_head,
    input  logic                   x_head,
    input  logic [NCELL*NODES-1:0] en,
    input  logic [NCELL*NODES-1:0] val,
    output logic                   y_tail,
    output logic                   x_tail
);
    logic [NCELL:0] y_link;
    logic [NCELL:0] x_link;

    assign y_link[0] = y_head;
    assign x_link[0] = x_head;

    for (genvar k = 0; k < NCELL; k++) begin : g_cell
        inject_t inj;
        assign inj.en  = en[k*NODES +: NODES];
        assign inj.val = val[k*NODES +: NODES];

        fta_cell u_cell (
            .clk    (clk),
            .rst    (rst),
            .mode   (mode),
            .t      (t),
            .y_prev (y_link[k]),
            .x_prev (x_link[k]),
            .inj    (inj),
            .g_o    (y_link[k+1]),
            .f_o    (x_link[k+1])
        );
    end

    assign y_tail = y_link[NCELL];
    assign x_tail = x_link[NCELL];

endmodule

// File: rtl/fta_array.sv
module fta_array
    import fta_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int NCELL = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         sel,
    input  logic                         t_in,
    input  logic [NCH-1:0]               y_in,
    input  logic [NCH-1:0]               x_in,
    input  logic [NCH*NCELL*NODES-1:0]   flt_en,
    input  logic [NCH*NCELL*NODES-1:0]   flt_val,
    output logic [NCH-1:0]               y_out,
    output logic [NCH-1:0]               x_out
);
    localparam int CH_BITS = NCELL * NODES;

    prop_mode_e mode;
    assign mode = prop_mode_e'(sel);

    for (genvar j = 0; j < NCH; j++) begin : g_chain
        fta_chain #(.NCELL(NCELL)) u_chain (
            .clk    (clk),
            .rst    (rst),
            .mode   (mode),
            .t      (t_in),
            .y_head (y_in[j]),
            .x_head (x_in[j]),
            .en     (flt_en[j*CH_BITS +: CH_BITS]),
            .val    (flt_val[j*CH_BITS +: CH_BITS]),
            .y_tail (y_out[j]),
            .x_tail (x_out[j])
        );
    end

endmodule

// File: rtl/fta_array_chk.sv
module fta_array_chk #(
    parameter int NCH   = 4,
    parameter int NCELL = 8
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     sel,
    input logic                     t_in,
    input logic [NCH-1:0]           y_in,
    input logic [NCH-1:0]           x_in,
    input logic [NCH*NCELL*4-1:0]   flt_en,
    input logic [NCH*NCELL*4-1:0]   flt_val,
    input logic [NCH-1:0]           y_out,
    input logic [NCH-1:0]           x_out
);
    logic no_flt;
    assign no_flt = (flt_en == '0);

    // R3: activation input dominates in AND mode
    a_r3_and_t_low: assert property (@(posedge clk) disable iff (rst)
        (no_flt && !sel && !t_in) |-> (y_out == '0 && x_out == '0));

    // R3: activation input dominates in OR mode
    a_r3_or_t_high: assert property (@(posedge clk) disable iff (rst)
        (no_flt && sel && t_in) |-> (y_out == '1 && x_out == '1));

    for (genvar j = 0; j < NCH; j++) begin : g_tail
        localparam int GIDX = (j*NCELL + NCELL-1)*4 + 0;
        localparam int FIDX = (j*NCELL + NCELL-1)*4 + 1;

        // R6: stuck transfer output of the last cell shows on y_out
        a_r6_tail_g: assert property (@(posedge clk) disable iff (rst)
            flt_en[GIDX] |-> (y_out[j] == flt_val[GIDX]));

        // R6: stuck feedback output of the last cell shows on x_out
        a_r6_tail_f: assert property (@(posedge clk) disable iff (rst)
            flt_en[FIDX] |-> (x_out[j] == flt_val[FIDX]));
    end

endmodule

bind fta_array fta_array_chk #(.NCH(NCH), .NCELL(NCELL)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .sel     (sel),
    .t_in    (t_in),
    .y_in    (y_in),
    .x_in    (x_in),
    .flt_en  (flt_en),
    .flt_val (flt_val),
    .y_out   (y_out),
    .x_out   (x_out)
);

// File: tb/fta_array_tb.sv
module fta_array_tb;
    localparam int PERIOD = 10;
    localparam int NCH    = 4;
    localparam int NCELL  = 8;
    localparam int FW     = NCH*NCELL*4;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           sel = 1'b0;
    logic           t_in = 1'b1;
    logic [NCH-1:0] y_in = '1;
    logic [NCH-1:0] x_in = '1;
    logic [FW-1:0]  flt_en = '0;
    logic [FW-1:0]  flt_val = '0;
    logic [NCH-1:0] y_out, x_out;

    int checks = 0;
    int errors = 0;

    always #(PERIOD/2) clk = ~clk;

    fta_array #(.NCH(NCH), .NCELL(NCELL)) u_dut (
        .clk(clk), .rst(rst), .sel(sel), .t_in(t_in),
        .y_in(y_in), .x_in(x_in), .flt_en(flt_en), .flt_val(flt_val),
        .y_out(y_out), .x_out(x_out)
    );

    function automatic logic ref_merge(logic m, logic a, logic b, logic c);
        return m ? (a | b | c) : (a & b & c);
    endfunction

    task automatic check(string req, logic [NCH-1:0] ay, logic [NCH-1:0] ax,
                         logic [NCH-1:0] ey, logic [NCH-1:0] ex);
        checks++;
        if (ay !== ey || ax !== ex) begin
            errors++;
            $display("FAIL %s y=%b x=%b expected y=%b x=%b", req, ay, ax, ey, ex);
        end
    endtask

    // Reset with the given stimulus held, then release
    task automatic apply(logic m, logic t, logic [NCH-1:0] yv, logic [NCH-1:0] xv,
                         logic [FW-1:0] en, logic [FW-1:0] val);
        @(negedge clk);
        sel = m; t_in = t; y_in = yv; x_in = xv; flt_en = en; flt_val = val;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(PERIOD*150000);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [NCH-1:0] ey, ex;
        logic           c;
        int             hits;
        void'($urandom(32'h5EED_0F7A));

        // R2: reset level in each mode
        apply(1'b0, 1'b1, '1, '1, '0, '0);
        check("R2 and-mode reset level", y_out, x_out, '1, '1);
        apply(1'b1, 1'b0, '0, '0, '0, '0);
        check("R2 or-mode reset level", y_out, x_out, '0, '0);

        // R3: activation dominates in the same cycle
        apply(1'b0, 1'b0, '1, '1, '0, '0);
        check("R3 and-mode t low", y_out, x_out, '0, '0);
        apply(1'b1, 1'b1, '0, '0, '0, '0);
        check("R3 or-mode t high", y_out, x_out, '1, '1);

        // R1: random fault-free patterns
        for (int i = 0; i < 40; i++) begin
            logic           m, t;
            logic [NCH-1:0] yv, xv;
            m = 1'($urandom); t = 1'($urandom);
            yv = NCH'($urandom); xv = NCH'($urandom);
            apply(m, t, yv, xv, '0, '0);
            repeat (NCELL) @(negedge clk);
            for (int j = 0; j < NCH; j++) ey[j] = ref_merge(m, t, yv[j], xv[j]);
            check("R1 fault-free combine", y_out, x_out, ey, ey);
        end

        // R4..R9: sweep every node, every stuck value
        for (int j = 0; j < NCH; j++)
        for (int k = 0; k < NCELL; k++)
        for (int n = 0; n < 4; n++)
        for (int v = 0; v < 2; v++) begin
            int idx;
            idx = (j*NCELL + k)*4 + n;
            hits = 0;
            for (int m = 0; m < 2; m++) begin
                logic [FW-1:0] en, val;
                string         req;
                en = '0; val = '0;
                en[idx] = 1'b1; val[idx] = 1'(v);
                c = 1'(m);                        // controlling value of the mode
                apply(1'(m), ~c, {NCH{~c}}, {NCH{~c}}, en, val);
                repeat (NCELL) @(negedge clk);
                ey = {NCH{~c}}; ex = {NCH{~c}};
                if (1'(v) == c) begin
                    ex[j] = c;
                    if (k < NCELL-1 || n == 0) ey[j] = c;
                    req = (k < NCELL-1) ? "R5 mid-chain fault (R4 R8)" : "R6 last-cell fault (R4 R8)";
                end else begin
                    req = "R7 non-controlling fault (R4 R8)";
                end
                check(req, y_out, x_out, ey, ex);
                if (y_out[j] !== ~c || x_out[j] !== ~c) hits++;
            end
            checks++;
            if (hits == 0) begin
                errors++;
                $display("FAIL R9 undetected chain %0d cell %0d node %0d stuck %0d hits=%0d expected>=1",
                         j, k, n, v, hits);
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule